// File: doc/BRIEF.md
# Two-Way LRU Read Cache Controller

This block sits between a processor's load/store path and a slow main memory and keeps a small copy of recently read words. It holds eight 32-bit words as two ways of four one-word lines, so an address splits into a set index and a tag with no offset field. A read that finds its word answers on the next cycle. A read that misses asks memory for the word and waits a fixed number of cycles. It then places the word in a free way of the set, or in the least recently read way if both are taken, and answers.

Writes are passed to memory in the cycle they are accepted and are never allocated. If the written word is already cached, its cached copy is refreshed, but the replacement order is not changed. A running count of the cycles spent waiting on memory is provided for profiling.

The request port uses valid/ready. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. While a read miss is outstanding `req_ready` stays low, so the requester must hold its request until it is accepted. The response side has no back-pressure. `rsp_valid` is a one-cycle pulse that the requester must take when it appears. Writes produce no response.

Top module: `rdcache2w`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0, `miss_total` is 0 and no way is valid, so the first read of any address misses.
- R2: The set index is address bits [3:2] and the tag is bits [31:4]. Addresses that differ only in the tag compete for the two ways of one set.
- R3: A read hit raises `rsp_valid` for one cycle, one cycle after acceptance, with the cached word. No memory read is issued.
- R4: A read miss raises `mem_rd_en` for exactly one cycle, the cycle after acceptance, with `mem_addr` equal to the request address. The word on `mem_rdata` is taken MEM_LAT (default 5) cycles after acceptance, and `rsp_valid` rises one cycle later with that word.
- R5: `miss_total` grows by MEM_LAT for every read miss and is unchanged by read hits and writes.
- R6: A write drives `mem_wr_en`, `mem_addr` and `mem_wdata` in its acceptance cycle and produces no response. A write whose word is not cached does not allocate, so a later read of it misses and returns the memory value.
- R7: A write whose word is cached also updates the cached copy, so a later read hits and returns the written value.
- R8: On a read miss an invalid way of the set is filled before any valid way is evicted.
- R9: On a read miss with both ways valid, the way that was not most recently read (by hit or fill) is replaced.
- R10: Writes leave the replacement order unchanged.
- R11: `req_ready` is low for the MEM_LAT cycles after a read miss is accepted, and no request is accepted during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address of the word |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle read response pulse |
| rsp_rdata | output | 32 | Read data |
| mem_rd_en | output | 1 | Memory read issue pulse |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid at the end of the fixed wait |
| miss_total | output | 32 | Accumulated miss wait cycles |

## Verification
One set is driven with a sequence that fills both ways, re-reads the older line, and then brings in a third tag. Which line survives shows whether replacement follows read recency or fill order. A write-hit placed just before a conflicting miss separates a design where writes touch the replacement state from one where they do not. A write-miss followed by a read of the same word separates no-allocate from allocate-on-write. In a second set, a write-hit read-back and a fill into the spare way check the data refresh and the invalid-way-first rule. Every transaction is timed, with its memory-read pulses and not-ready cycles counted, so hits, misses and the miss counter are each checked against their own expected values.

// File: rtl/rdc_pkg.sv
package rdc_pkg;
  localparam int WAYS = 2;
  typedef enum logic {ST_IDLE = 1'b0, ST_WAIT = 1'b1} rdc_state_e;
endpackage

// File: rtl/rdc_way_store.sv
module rdc_way_store #(
  parameter int SETS   = 4,
  parameter int TAG_W  = 28,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  lk_set,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              lk_hit,
  output logic              lk_vld,
  output logic [DATA_W-1:0] lk_data,
  input  logic              fill_en,
  input  logic              upd_en,
  input  logic [IDX_W-1:0]  wr_set,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);
  logic [SETS-1:0]   vld_q;
  logic [TAG_W-1:0]  tag_q [SETS];
  logic [DATA_W-1:0] dat_q [SETS];

  always_ff @(posedge clk) begin
    if (!rst_n) vld_q <= '0;
    else if (fill_en) vld_q[wr_set] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[wr_set] <= wr_tag;
    if (fill_en || upd_en) dat_q[wr_set] <= wr_data;
  end

  always_comb begin
    lk_vld  = vld_q[lk_set];
    lk_hit  = lk_vld && (tag_q[lk_set] == lk_tag);
    lk_data = dat_q[lk_set];
  end

  for (genvar k = 0; k < SETS; k++) begin : g_vchk
    // R6
    vld_only_on_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vld_q[k]) |-> $past(fill_en && (wr_set == IDX_W'(k))));
  end
endmodule

// File: rtl/rdc_lru.sv
module rdc_lru #(
  parameter int SETS = 4,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_set,
  output logic             victim,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_set,
  input  logic             touch_way,
  output logic [SETS-1:0]  state_o
);
  logic [SETS-1:0] vic_q;

  always_ff @(posedge clk) begin
    if (!rst_n) vic_q <= '0;
    else if (touch_en) vic_q[touch_set] <= ~touch_way;
  end

  assign victim  = vic_q[rd_set];
  assign state_o = vic_q;
endmodule

// File: rtl/rdc_miss_ctr.sv
module rdc_miss_ctr #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] total
);
  always_ff @(posedge clk) begin
    if (!rst_n) total <= '0;
    else if (inc) total <= total + 1'b1;
  end
endmodule

// File: rtl/rdcache2w.sv
module rdcache2w
  import rdc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int SETS    = 4,
  parameter int MEM_LAT = 5,
  parameter int CNT_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [CNT_W-1:0]  miss_total
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - 2 - IDX_W;
  localparam int LAT_W = $clog2(MEM_LAT + 1);

  rdc_state_e        state_q;
  logic [LAT_W-1:0]  wcnt_q;
  logic [ADDR_W-1:0] maddr_q;
  logic              vway_q;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_data_q;

  logic              fire, rd_fire, wr_fire, any_hit, hit_way, fill_done;
  logic              lru_victim, pick_way, touch_en, touch_way;
  logic [IDX_W-1:0]  req_set, miss_set, wr_set, touch_set;
  logic [TAG_W-1:0]  req_tag, miss_tag, wr_tag;
  logic [DATA_W-1:0] wr_data, hit_data;
  logic [WAYS-1:0]   hit_vec, vld_vec, fill_vec, upd_vec;
  logic [DATA_W-1:0] way_data [WAYS];
  logic [SETS-1:0]   lru_state;

  assign req_ready = (state_q == ST_IDLE);
  assign fire      = req_valid && req_ready;
  assign rd_fire   = fire && !req_write;
  assign wr_fire   = fire && req_write;
  assign fill_done = (state_q == ST_WAIT) && (wcnt_q == LAT_W'(MEM_LAT - 1));

  assign req_set  = req_addr[IDX_W+1:2];
  assign req_tag  = req_addr[ADDR_W-1:IDX_W+2];
  assign miss_set = maddr_q[IDX_W+1:2];
  assign miss_tag = maddr_q[ADDR_W-1:IDX_W+2];
  assign wr_set   = fill_done ? miss_set : req_set;
  assign wr_tag   = fill_done ? miss_tag : req_tag;
  assign wr_data  = fill_done ? mem_rdata : req_wdata;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign fill_vec[w] = fill_done && (vway_q == w[0]);
    assign upd_vec[w]  = wr_fire && hit_vec[w];
    rdc_way_store #(.SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) way_i (
      .clk(clk), .rst_n(rst_n),
      .lk_set(req_set), .lk_tag(req_tag),
      .lk_hit(hit_vec[w]), .lk_vld(vld_vec[w]), .lk_data(way_data[w]),
      .fill_en(fill_vec[w]), .upd_en(upd_vec[w]),
      .wr_set(wr_set), .wr_tag(wr_tag), .wr_data(wr_data)
    );
  end

  assign any_hit  = |hit_vec;
  assign hit_way  = hit_vec[1];
  assign hit_data = hit_way ? way_data[1] : way_data[0];
  assign pick_way = !vld_vec[0] ? 1'b0 : (!vld_vec[1] ? 1'b1 : lru_victim);

  assign touch_en  = (rd_fire && any_hit) || fill_done;
  assign touch_set = fill_done ? miss_set : req_set;
  assign touch_way = fill_done ? vway_q : hit_way;

  rdc_lru #(.SETS(SETS)) lru_i (
    .clk(clk), .rst_n(rst_n), .rd_set(req_set), .victim(lru_victim),
    .touch_en(touch_en), .touch_set(touch_set), .touch_way(touch_way),
    .state_o(lru_state)
  );

  rdc_miss_ctr #(.CNT_W(CNT_W)) ctr_i (
    .clk(clk), .rst_n(rst_n), .inc(state_q == ST_WAIT), .total(miss_total)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      wcnt_q      <= '0;
      maddr_q     <= '0;
      vway_q      <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (rd_fire && any_hit) begin
            rsp_valid_q <= 1'b1;
            rsp_data_q  <= hit_data;
          end else if (rd_fire) begin
            state_q <= ST_WAIT;
            wcnt_q  <= '0;
            maddr_q <= req_addr;
            vway_q  <= pick_way;
          end
        end
        ST_WAIT: begin
          if (fill_done) begin
            state_q     <= ST_IDLE;
            rsp_valid_q <= 1'b1;
            rsp_data_q  <= mem_rdata;
          end else begin
            wcnt_q <= wcnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_data_q;
  assign mem_rd_en = (state_q == ST_WAIT) && (wcnt_q == '0);
  assign mem_wr_en = wr_fire;
  assign mem_addr  = (state_q == ST_WAIT) ? maddr_q : req_addr;
  assign mem_wdata = req_wdata;

  // R8
  hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
  // R10
  wr_keeps_lru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> $stable(lru_state));
  // R5
  miss_count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> (miss_total == $past(miss_total) + 1'b1));
  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && !fill_done) |=> !req_ready);
  // R3
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready);
endmodule

// File: tb/rdcache2w_tb_top.sv
`timescale 1ns/1ps
module rdcache2w_tb_top;
  localparam int LAT = 5;

  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic        hit;
    logic [31:0] data;
  } vec_t;

  // Expected results worked out from the requirements (set = addr[3:2]).
  localparam vec_t VECS [18] = '{
    '{1'b0, 32'h00, 32'h0,         1'b0, 32'h1000_0000}, // R1 cold miss
    '{1'b0, 32'h00, 32'h0,         1'b1, 32'h1000_0000}, // R3
    '{1'b0, 32'h10, 32'h0,         1'b0, 32'h1000_0004}, // R2 R8 same set
    '{1'b0, 32'h00, 32'h0,         1'b1, 32'h1000_0000}, // R9 make 0x10 oldest
    '{1'b0, 32'h20, 32'h0,         1'b0, 32'h1000_0008}, // R9 evicts 0x10
    '{1'b0, 32'h00, 32'h0,         1'b1, 32'h1000_0000}, // R9 0x00 kept
    '{1'b0, 32'h10, 32'h0,         1'b0, 32'h1000_0004}, // R9 evicts 0x20
    '{1'b1, 32'h20, 32'hDEAD_0020, 1'b0, 32'h0},         // R6 write miss
    '{1'b0, 32'h20, 32'h0,         1'b0, 32'hDEAD_0020}, // R6 no allocate
    '{1'b1, 32'h10, 32'hBEEF_0010, 1'b0, 32'h0},         // R10 write hit
    '{1'b0, 32'h00, 32'h0,         1'b0, 32'h1000_0000}, // R10 evicts 0x10
    '{1'b0, 32'h20, 32'h0,         1'b1, 32'hDEAD_0020}, // R10 0x20 kept
    '{1'b0, 32'h04, 32'h0,         1'b0, 32'h1000_0001}, // R2 set 1
    '{1'b1, 32'h04, 32'hBEEF_0004, 1'b0, 32'h0},         // R7
    '{1'b0, 32'h04, 32'h0,         1'b1, 32'hBEEF_0004}, // R7 read back
    '{1'b0, 32'h14, 32'h0,         1'b0, 32'h1000_0005}, // R8 free way
    '{1'b0, 32'h04, 32'h0,         1'b1, 32'hBEEF_0004}, // R8 kept
    '{1'b0, 32'h10, 32'h0,         1'b0, 32'hBEEF_0010}  // R6 memory holds write
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        req_ready, rsp_valid, mem_rd_en, mem_wr_en;
  logic [31:0] rsp_rdata, mem_addr, mem_wdata, mem_rdata, miss_total;
  logic [31:0] mem [64];
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  rdcache2w dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_rd_en(mem_rd_en),
    .mem_wr_en(mem_wr_en), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .miss_total(miss_total)
  );

  initial for (int i = 0; i < 64; i++) mem[i] = 32'h1000_0000 + i;
  always @(posedge clk) if (mem_wr_en) mem[mem_addr[7:2]] <= mem_wdata;
  assign mem_rdata = mem[mem_addr[7:2]];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    int lat, rdc, rlow;
    logic [31:0] mt0;
    mt0 = miss_total;
    req_valid = 1'b1; req_write = v.wr; req_addr = v.addr; req_wdata = v.wdata;
    #1;
    if (v.wr) begin
      chk(mem_wr_en == 1'b1, "R6", $sformatf("v%0d wr strobe", idx), 32'(mem_wr_en), 32'h1);
      chk(mem_addr == v.addr && mem_wdata == v.wdata, "R6",
          $sformatf("v%0d wr data", idx), mem_wdata, v.wdata);
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1; rdc = 0; rlow = 0;
    if (!v.wr) begin
      while (!rsp_valid && lat < 50) begin
        if (mem_rd_en) begin
          rdc++;
          chk(mem_addr == v.addr, "R4", $sformatf("v%0d rd addr", idx), mem_addr, v.addr);
        end
        if (!req_ready) rlow++;
        @(negedge clk);
        lat++;
      end
      chk(rsp_rdata == v.data, v.hit ? "R3" : "R4", $sformatf("v%0d data", idx), rsp_rdata, v.data);
      chk(lat == (v.hit ? 1 : LAT + 1), v.hit ? "R3" : "R4", $sformatf("v%0d latency", idx),
          32'(lat), 32'(v.hit ? 1 : LAT + 1));
      chk(rdc == (v.hit ? 0 : 1), "R4", $sformatf("v%0d rd pulses", idx), 32'(rdc), 32'(v.hit ? 0 : 1));
      chk(rlow == (v.hit ? 0 : LAT), "R11", $sformatf("v%0d not-ready cycles", idx),
          32'(rlow), 32'(v.hit ? 0 : LAT));
      chk(miss_total - mt0 == (v.hit ? 0 : LAT), "R5", $sformatf("v%0d miss delta", idx),
          miss_total - mt0, 32'(v.hit ? 0 : LAT));
    end else begin
      chk(rsp_valid == 1'b0, "R6", $sformatf("v%0d no response", idx), 32'(rsp_valid), 32'h0);
      chk(req_ready == 1'b1, "R6", $sformatf("v%0d ready", idx), 32'(req_ready), 32'h1);
      chk(miss_total == mt0, "R5", $sformatf("v%0d miss delta", idx), miss_total - mt0, 32'h0);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready in reset", 32'(req_ready), 32'h1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready after reset", 32'(req_ready), 32'h1);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 32'(rsp_valid), 32'h0);
    chk(miss_total == 32'h0, "R1", "miss_total after reset", miss_total, 32'h0);
    chk(mem_rd_en == 1'b0, "R1", "no read after reset", 32'(mem_rd_en), 32'h0);
    for (int i = 0; i < 18; i++) run_vec(VECS[i], i);
    chk(miss_total == 32'(9 * LAT), "R5", "final miss total", miss_total, 32'(9 * LAT));
    // R1: reset again, previously cached word must miss
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(miss_total == 32'h0, "R1", "counter cleared", miss_total, 32'h0);
    run_vec('{1'b0, 32'h04, 32'h0, 1'b0, 32'hBEEF_0004}, 100);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R4 watchdog: actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule